// File: doc/BRIEF.md
# Performance monitor mode flag generator

This block turns the state of a performance-monitor control register, the processor's privilege and hypervisor state, a feature strap and a small counter-enable vector into six registered mode flags. Downstream logic uses the flags to decide whether counter access instructions are allowed, whether counters chain, whether instruction counting is live and whether branch-history recording may run.

The flags are captured on an update strobe. Each capture also produces a full-width flag word. In merge mode the block rewrites only the six positions it owns inside a caller-supplied word and passes every other bit through. In full mode it builds the word from its own flags alone. A constant mask output marks the owned positions.

Top module: `pmu_mode_flags`

## Requirements
- R1: A synchronous reset clears `flags` and `word_out` to zero.
- R2: On an update, flag bit 0 takes `ctl_acc0`, bit 1 takes `ctl_acc1` and bit 2 takes `ctl_chain`.
- R3: When `newisa` is 1, flag bit 5 (branch-history enable) is 0 if `ctl_bhdis` is 1 or `st_pr` is 0. These conditions override the freeze rules below.
- R4: When `ctl_fcpc` is 0, branch history is frozen (bit 5 = 0) exactly when `ctl_fcp` and `st_pr` are both 1. Otherwise bit 5 is 1.
- R5: When `ctl_fcpc` is 1 and `ctl_fcp` is 1, bit 5 is 0 exactly when `st_hv` and `st_pr` are both 1.
- R6: When `ctl_fcpc` is 1 and `ctl_fcp` is 0, bit 5 is 0 exactly when `st_hv` is 0 and `st_pr` is 1.
- R7: Flag bit 3 (instruction counting) is 1 when any bit of `cnt_en` is set.
- R8: Flag bit 4 (other counters) is 1 when any of `cnt_en[4:1]` is set. `cnt_en[0]` alone leaves it at 0.
- R9: In merge mode (`merge`=1), `word_out` equals `word_in` at every position outside the owned mask. The six flags are placed at word bits 8 to 13, in flag order.
- R10: In full mode (`merge`=0), every `word_out` bit outside the owned mask is 0.
- R11: Outputs change one cycle after a cycle with `upd`=1 and hold their value while `upd` is 0, whatever the other inputs do.
- R12: `own_mask` has exactly bits 8 to 13 set (32'h0000_3F00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Update strobe |
| merge | input | 1 | 1: merge into word_in; 0: full rebuild |
| newisa | input | 1 | Feature strap enabling the extra branch-history gating |
| ctl_acc0 | input | 1 | Counter access control bit 0 |
| ctl_acc1 | input | 1 | Counter access control bit 1 |
| ctl_chain | input | 1 | Counter chaining enable |
| ctl_fcp | input | 1 | Freeze while in problem state |
| ctl_fcpc | input | 1 | Freeze condition select |
| ctl_bhdis | input | 1 | Branch-history disable |
| st_pr | input | 1 | Problem (user) state |
| st_hv | input | 1 | Hypervisor state |
| cnt_en | input | 5 | Per-counter instruction count enables |
| word_in | input | 32 | Word to merge into |
| flags | output | 6 | Registered flags {bh_en, other, icnt, chain, acc1, acc0} |
| own_mask | output | 32 | Positions owned in the word |
| word_out | output | 32 | Registered flag word |

## Verification
The embedded properties check every cycle that each flag follows its inputs from the strobe cycle, that the word's foreign bits are passed through or zeroed as the mode says, and that nothing moves without a strobe. The new-ISA override and the three freeze branches each have their own property. Only the bench scenarios show that the bench's independent reading of the freeze table matches, across many combinations, and that the mask has the fixed value. They also show the reset state and that the flags appear at the documented word positions.

// File: rtl/pmu_mode_flags.sv
module pmu_mode_flags #(
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 5,
  parameter int POS_BASE = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              merge,
  input  logic              newisa,
  input  logic              ctl_acc0,
  input  logic              ctl_acc1,
  input  logic              ctl_chain,
  input  logic              ctl_fcp,
  input  logic              ctl_fcpc,
  input  logic              ctl_bhdis,
  input  logic              st_pr,
  input  logic              st_hv,
  input  logic [CNT_W-1:0]  cnt_en,
  input  logic [WORD_W-1:0] word_in,
  output logic [5:0]        flags,
  output logic [WORD_W-1:0] own_mask,
  output logic [WORD_W-1:0] word_out
);
  localparam int NFLAG = 6;

  logic              frozen, bh_block, bh_en;
  logic [NFLAG-1:0]  nxt;
  logic [WORD_W-1:0] placed, mask_c;

  always_comb begin
    if (ctl_fcpc) frozen = st_pr & (ctl_fcp ? st_hv : ~st_hv);
    else          frozen = st_pr & ctl_fcp;
  end

  assign bh_block = newisa & (ctl_bhdis | ~st_pr);
  assign bh_en    = ~bh_block & ~frozen;
  assign nxt      = {bh_en, |cnt_en[CNT_W-1:1], |cnt_en, ctl_chain, ctl_acc1, ctl_acc0};

  always_comb begin
    placed = '0;
    mask_c = '0;
    for (int i = 0; i < NFLAG; i++) begin
      placed[POS_BASE+i] = nxt[i];
      mask_c[POS_BASE+i] = 1'b1;
    end
  end

  assign own_mask = mask_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      word_out <= '0;
    end else if (upd) begin
      flags    <= nxt;
      word_out <= merge ? ((word_in & ~mask_c) | placed) : placed;
    end
  end

  p_copy_r2: assert property (@(posedge clk) disable iff (rst)
    upd |=> flags[2:0] == {$past(ctl_chain), $past(ctl_acc1), $past(ctl_acc0)});
  p_newisa_r3: assert property (@(posedge clk) disable iff (rst)
    (upd && newisa && (ctl_bhdis || !st_pr)) |=> !flags[5]);
  p_fcpc0_r4: assert property (@(posedge clk) disable iff (rst)
    (upd && !newisa && !ctl_fcpc) |=> flags[5] == !($past(ctl_fcp) && $past(st_pr)));
  p_fcpc1_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && !newisa && ctl_fcpc && ctl_fcp) |=> flags[5] == !($past(st_hv) && $past(st_pr)));
  p_fcpc1_r6: assert property (@(posedge clk) disable iff (rst)
    (upd && !newisa && ctl_fcpc && !ctl_fcp) |=> flags[5] == !(!$past(st_hv) && $past(st_pr)));
  p_icnt_r7: assert property (@(posedge clk) disable iff (rst)
    upd |=> flags[3] == ($past(cnt_en) != '0));
  p_other_r8: assert property (@(posedge clk) disable iff (rst)
    upd |=> flags[4] == ($past(cnt_en[CNT_W-1:1]) != '0));
  p_merge_r9: assert property (@(posedge clk) disable iff (rst)
    (upd && merge) |=> (word_out & ~own_mask) == ($past(word_in) & ~own_mask));
  p_full_r10: assert property (@(posedge clk) disable iff (rst)
    (upd && !merge) |=> (word_out & ~own_mask) == '0);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(word_out) && $stable(flags));
  p_place_r9: assert property (@(posedge clk) disable iff (rst)
    upd |=> ((word_out >> POS_BASE) & 6'h3F) == WORD_W'(flags));
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (word_out == '0) && (flags == '0));
endmodule

// File: tb/pmu_mode_flags_test.sv
`timescale 1ns/1ps
module pmu_mode_flags_test;
  logic clk = 0, rst = 1, upd = 0, merge = 0, newisa = 0;
  logic ctl_acc0 = 0, ctl_acc1 = 0, ctl_chain = 0, ctl_fcp = 0, ctl_fcpc = 0, ctl_bhdis = 0;
  logic st_pr = 0, st_hv = 0;
  logic [4:0]  cnt_en = 0;
  logic [31:0] word_in = 0;
  logic [5:0]  flags;
  logic [31:0] own_mask, word_out;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [37:0] sb[$];
  string tags[$];

  always #2 clk = ~clk;

  pmu_mode_flags uut (.clk, .rst, .upd, .merge, .newisa, .ctl_acc0, .ctl_acc1, .ctl_chain,
    .ctl_fcp, .ctl_fcpc, .ctl_bhdis, .st_pr, .st_hv, .cnt_en, .word_in, .flags, .own_mask, .word_out);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic bh_model(logic ni, logic dis, logic pr, logic hv, logic fcp, logic fcpc);
    if (ni && dis) return 0;
    if (ni && !pr) return 0;
    case ({fcpc, fcp, hv, pr})
      4'b0101, 4'b0111: return 0;    // R4 freeze
      4'b1111:          return 0;    // R5 freeze
      4'b1001:          return 0;    // R6 freeze
      default:          return 1;
    endcase
  endfunction

  task automatic apply(string tag, logic mg, logic ni, logic a0, logic a1, logic ch,
                       logic fcp, logic fcpc, logic dis, logic pr, logic hv,
                       logic [4:0] ce, logic [31:0] win);
    logic [5:0] f;
    logic [31:0] w;
    @(negedge clk);
    merge = mg; newisa = ni; ctl_acc0 = a0; ctl_acc1 = a1; ctl_chain = ch;
    ctl_fcp = fcp; ctl_fcpc = fcpc; ctl_bhdis = dis; st_pr = pr; st_hv = hv;
    cnt_en = ce; word_in = win; upd = 1;
    f = {bh_model(ni, dis, pr, hv, fcp, fcpc), ce[1] | ce[2] | ce[3] | ce[4],
         ce != 0, ch, a1, a0};
    w = {18'b0, f, 8'b0};
    if (mg) w = w | (win & 32'hFFFF_C0FF);
    sb.push_back({f, w});
    tags.push_back(tag);
    @(negedge clk);
    upd = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (upd === 1'b1 && rst === 1'b0) begin
        logic [37:0] e;
        string t;
        @(negedge clk);
        e = sb.pop_front();
        t = tags.pop_front();
        check({t, " flags"}, 64'(flags), 64'(e[37:32]));
        check({t, " word"}, 64'(word_out), 64'(e[31:0]));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    word_in = 32'hFFFF_FFFF; cnt_en = 5'h1F; ctl_acc0 = 1;
    repeat (3) @(negedge clk);
    check("R1 reset flags", 64'(flags), 0);
    check("R1 reset word", 64'(word_out), 0);
    check("R12 mask", 64'(own_mask), 64'h3F00);
    rst = 0;
    @(negedge clk);
    apply("R2 acc0", 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 5'h00, 32'h0);
    apply("R2 acc1+chain", 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 5'h00, 32'h0);
    apply("R3 disable bit", 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 5'h00, 32'h0);
    apply("R3 supervisor", 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 5'h00, 32'h0);
    apply("R3 user allowed", 0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 5'h00, 32'h0);
    apply("R3 override freeze", 0, 1, 0, 0, 0, 1, 0, 0, 1, 0, 5'h00, 32'h0);
    for (int i = 0; i < 16; i++)
      apply("R4/R5/R6 freeze table", 0, 0, 0, 0, 0, i[2], i[3], 0, i[0], i[1], 5'h00, 32'h0);
    apply("R4 frozen", 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 5'h00, 32'h0);
    apply("R5 frozen", 0, 0, 0, 0, 0, 1, 1, 0, 1, 1, 5'h00, 32'h0);
    apply("R6 frozen", 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 5'h00, 32'h0);
    apply("R7 R8 bit0 only", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5'h01, 32'h0);
    apply("R8 bit4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5'h10, 32'h0);
    apply("R7 R8 bits", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5'h06, 32'h0);
    apply("R9 merge ones", 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 5'h01, 32'hFFFF_FFFF);
    apply("R9 merge pattern", 1, 1, 0, 1, 0, 1, 1, 1, 1, 1, 5'h08, 32'hA5A5_5A5A);
    apply("R10 full", 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 5'h1F, 32'hFFFF_FFFF);
    apply("R11 setup", 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 5'h03, 32'h1234_5678);
    begin
      logic [31:0] wsave;
      logic [5:0] fsave;
      wsave = word_out; fsave = flags;
      merge = 0; ctl_acc0 = 0; ctl_acc1 = 1; cnt_en = 0; word_in = 32'h0; st_pr = 1; ctl_fcp = 1;
      repeat (4) @(negedge clk);
      check("R11 hold word", 64'(word_out), 64'(wsave));
      check("R11 hold flags", 64'(flags), 64'(fsave));
    end
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 second reset", 64'(word_out), 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule